// File: doc/BRIEF.md
# Row-Wrapping I2C Slave With Busy Polling

This block is an I2C target that samples the bus lines with the system clock. It finds START, repeated START and STOP conditions on its own and answers to a 7-bit address whose upper four bits are fixed at 1010 and whose lower three bits come from strap pins. Behind the bus logic sits a byte-wide store reached through one internal address pointer. The same pointer serves writes and reads.

A write transaction carries the memory address in its second byte and data bytes after that. Data writes stay inside the 8-byte row that the pointer points into: the pointer wraps from the last byte of the row back to its first byte. A STOP that ends a transaction with at least one data byte starts a commit interval of a set number of cycles. During that interval the block does not acknowledge its own address, so a host can poll with address bytes until it gets an acknowledge. Reads start at the current pointer, and the pointer then counts on freely across row boundaries. SDA is never driven high: the block only gives an enable that pulls the line low.

Top module: `i2c_row_slave`

## Requirements
- R1: After reset the SDA pull-down enable is 0 and no commit interval is running.
- R2: The block acknowledges an address byte whose upper seven bits, MSB first, are 1010 followed by pin_addr[2:0]. Bit 0 of that byte selects the direction: 0 is a write and 1 is a read. The acknowledge is SDA held low during the ninth clock.
- R3: After an address byte that does not match, the block acknowledges nothing, drives nothing and stores nothing until the next START.
- R4: In a write, the first byte after the address loads the pointer. Each following byte is stored at the pointer, and then bits 2:0 of the pointer increment modulo 8 while bits 7:3 stay fixed. Every byte is acknowledged.
- R5: A STOP after a write that stored data starts a commit interval of BUSY_CYCLES clock cycles. During that interval the block's address is not acknowledged. After the interval it is acknowledged again.
- R6: A read returns the byte at the current pointer. A write of the address byte and pointer byte followed by a repeated START sets where the read begins. A read started directly continues from where the pointer was left.
- R7: During a read the pointer increments by one after each byte is loaded, and it carries across row boundaries.
- R8: Bytes move MSB first. The block changes SDA only while SCL is low, after a falling edge. Data is valid at the rising edge.
- R9: When the master does not acknowledge a read byte, the block releases SDA and stays released until the next START.
- R10: A write transaction that ends at STOP without any data byte starts no commit interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL level from the pad |
| sda_in | input | 1 | SDA level from the pad |
| pin_addr | input | 3 | Strap bits for the low three address bits |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The commit interval is the hardest case to reach. It only starts when a STOP follows a write that stored at least one byte, and it can only be seen as a missing acknowledge on a later address byte. The bench issues such a write and polls the address right after the STOP. It then waits out the interval and polls again. It also ends an address-plus-pointer write with STOP and polls at once, which shows that no interval started. Row wrap and the free-running read pointer are reached by writing at the end of a row and reading back through the following row.

// File: rtl/i2c_row_pkg.sv
package i2c_row_pkg;
  localparam logic [3:0] DEV_ID = 4'b1010;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_WADDR,
    S_WAACK,
    S_WDATA,
    S_WDACK,
    S_RDATA,
    S_RACK,
    S_SKIP
  } bus_state_t;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] scl_meta, sda_meta;
  logic       scl_p, sda_p;
  logic       scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_meta <= 2'b11;
      sda_meta <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_meta <= {scl_meta[0], scl_in};
      sda_meta <= {sda_meta[0], sda_in};
      scl_p    <= scl_meta[1];
      sda_p    <= sda_meta[1];
    end
  end

  assign scl_s     = scl_meta[1];
  assign sda_s     = sda_meta[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_row_mem.sv
module i2c_row_mem #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/i2c_busy_timer.sv
module i2c_busy_timer #(
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic commit,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (commit)        remain <= CW'(BUSY_CYCLES);
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/i2c_row_slave.sv
module i2c_row_slave
  import i2c_row_pkg::*;
#(
  parameter int AW          = 8,
  parameter int ROW_BYTES   = 8,
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] pin_addr,
  output logic       sda_oe
);
  localparam int ROW_W = $clog2(ROW_BYTES);

  logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          busy, commit;
  bus_state_t    state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg;
  logic          rw, wrote_any, m_ack, sda_oe_q;
  logic [AW-1:0] ptr, wr_addr;
  logic [7:0]    wr_data, rd_data;
  logic          wr_en;

  i2c_bus_sync u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_row_mem #(.AW(AW)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rd_data)
  );

  assign commit = stop_det & wrote_any;

  i2c_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .commit(commit), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      rw        <= 1'b0;
      wrote_any <= 1'b0;
      m_ack     <= 1'b0;
      sda_oe_q  <= 1'b0;
      ptr       <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_en     <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= S_ADDR;
        bit_cnt  <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_det) begin
        state     <= S_IDLE;
        sda_oe_q  <= 1'b0;
        wrote_any <= 1'b0;
      end else begin
        case (state)
          S_ADDR, S_WADDR, S_WDATA: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == S_ADDR) begin
                if (shreg[7:1] == {DEV_ID, pin_addr} && !busy) begin
                  sda_oe_q <= 1'b1;
                  rw       <= shreg[0];
                  state    <= S_AACK;
                end else begin
                  state <= S_SKIP;
                end
              end else if (state == S_WADDR) begin
                ptr      <= shreg[AW-1:0];
                sda_oe_q <= 1'b1;
                state    <= S_WAACK;
              end else begin
                wr_en     <= 1'b1;
                wr_addr   <= ptr;
                wr_data   <= shreg;
                ptr       <= {ptr[AW-1:ROW_W], ptr[ROW_W-1:0] + 1'b1};
                wrote_any <= 1'b1;
                sda_oe_q  <= 1'b1;
                state     <= S_WDACK;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              if (rw) begin
                shreg    <= rd_data;
                sda_oe_q <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                bit_cnt  <= '0;
                state    <= S_RDATA;
              end else begin
                sda_oe_q <= 1'b0;
                state    <= S_WADDR;
              end
            end
          end
          S_WAACK, S_WDACK: begin
            if (scl_fall) begin
              sda_oe_q <= 1'b0;
              state    <= S_WDATA;
            end
          end
          S_RDATA: begin
            if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == 4'd8) begin
                sda_oe_q <= 1'b0;
                state    <= S_RACK;
              end else begin
                shreg    <= {shreg[6:0], 1'b0};
                sda_oe_q <= ~shreg[6];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (m_ack) begin
                shreg    <= rd_data;
                sda_oe_q <= ~rd_data[7];
                ptr      <= ptr + 1'b1;
                bit_cnt  <= '0;
                state    <= S_RDATA;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = sda_oe_q;
endmodule

// File: rtl/i2c_row_slave_chk.sv
module i2c_row_slave_chk #(
  parameter int AW    = 8,
  parameter int RW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          scl_in,
  input logic          sda_oe,
  input logic          busy,
  input logic          stop_det,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] ptr
);
  // R1: released right after reset
  assert_release_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> !sda_oe);

  // R8: pull-down only begins while SCL is low
  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_in);

  // R4: a data write leaves the pointer in the same row
  assert_row_kept_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ptr[AW-1:RW] == wr_addr[AW-1:RW]);

  // R5: no store happens while a commit interval runs
  assert_no_write_busy_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy);

  // R10: commit interval only begins after a STOP
  assert_busy_after_stop_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));
endmodule

bind i2c_row_slave i2c_row_slave_chk #(.AW(AW), .RW(ROW_W)) u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe), .busy(busy),
  .stop_det(stop_det), .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr)
);

// File: tb/i2c_row_slave_tb.sv
`timescale 1ns/1ps
module i2c_row_slave_tb;
  localparam int BUSY = 2000;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'b101;
  logic sda_oe;
  logic sda_line;

  assign sda_line = sda_m & ~sda_oe;

  i2c_row_slave #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .pin_addr(pins), .sda_oe(sda_oe)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_byte;
  event       obs_ev;

  localparam logic [7:0] AW_ME = {4'b1010, 3'b101, 1'b0};
  localparam logic [7:0] AR_ME = {4'b1010, 3'b101, 1'b1};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1; wq(Q); scl_m = 1; wq(Q); sda_m = 0; wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 0; wq(Q); scl_m = 1; wq(Q); sda_m = 1; wq(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    end
    sda_m = 1; wq(Q); scl_m = 1; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q); scl_m = 0; wq(Q);
  endtask

  task automatic get_byte(input bit give_ack);
    logic [7:0] b;
    b = '0;
    sda_m = 1;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_m = 1; wq(Q); b = {b[6:0], sda_line}; wq(Q); scl_m = 0;
    end
    wq(Q); sda_m = give_ack ? 1'b0 : 1'b1; wq(Q); scl_m = 1; wq(2*Q); scl_m = 0; wq(Q);
    sda_m = 1;
    obs_byte = b;
    -> obs_ev;
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", obs_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(obs_byte == e, t, obs_byte, e);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit a;
    wq(5);
    check(sda_oe == 1'b0, "R1 sda released in reset", sda_oe, 0);
    rst = 0;
    wq(5);
    check(sda_oe == 1'b0, "R1 sda released after reset", sda_oe, 0);

    // R2 R4: write three bytes at 0x10
    i2c_start();
    put_byte(AW_ME, a); check(a, "R2 address ack", a, 1);
    put_byte(8'h10, a); check(a, "R4 pointer ack", a, 1);
    put_byte(8'h11, a); check(a, "R4 data ack", a, 1);
    put_byte(8'h22, a);
    put_byte(8'h33, a); check(a, "R4 third data ack", a, 1);
    i2c_stop();

    // R5: polled during commit interval
    i2c_start();
    put_byte(AW_ME, a); check(!a, "R5 nack while busy", a, 0);
    i2c_stop();
    wq(BUSY + 100);
    i2c_start();
    put_byte(AW_ME, a); check(a, "R5 ack after interval", a, 1);
    put_byte(8'h10, a);
    // R6: repeated START read from set pointer, R9 nack ends
    i2c_start();
    put_byte(AR_ME, a); check(a, "R2 read address ack", a, 1);
    expect_rd("R6 read byte0", 8'h11);
    get_byte(1);
    expect_rd("R8 read byte1 msb first", 8'h22);
    get_byte(1);
    expect_rd("R6 read byte2", 8'h33);
    get_byte(0);
    wq(5);
    check(sda_oe == 1'b0, "R9 released after master nack", sda_oe, 0);
    scl_m = 1; wq(Q); scl_m = 0; wq(Q);
    check(sda_oe == 1'b0, "R9 stays released", sda_oe, 0);
    i2c_stop();

    // R10: pointer-only write starts no interval
    i2c_start();
    put_byte(AW_ME, a);
    put_byte(8'hC0, a);
    i2c_stop();
    i2c_start();
    put_byte(AW_ME, a); check(a, "R10 no busy without data", a, 1);
    put_byte(8'hC0, a);
    put_byte(8'h5A, a);
    put_byte(8'h6B, a);
    i2c_stop();
    wq(BUSY + 100);

    // R4: wrap inside row 0xB8..0xBF
    i2c_start();
    put_byte(AW_ME, a);
    put_byte(8'hBE, a);
    put_byte(8'hAA, a);
    put_byte(8'hBB, a);
    put_byte(8'hCC, a); check(a, "R4 wrap byte ack", a, 1);
    i2c_stop();
    wq(BUSY + 100);

    i2c_start();
    put_byte(AW_ME, a);
    put_byte(8'hB8, a);
    i2c_start();
    put_byte(AR_ME, a);
    expect_rd("R4 wrapped byte at B8", 8'hCC);
    get_byte(0);
    i2c_stop();

    // R7: read crosses row boundary BE,BF,C0
    i2c_start();
    put_byte(AW_ME, a);
    put_byte(8'hBE, a);
    i2c_start();
    put_byte(AR_ME, a);
    expect_rd("R7 read BE", 8'hAA);
    get_byte(1);
    expect_rd("R7 read BF", 8'hBB);
    get_byte(1);
    expect_rd("R7 read C0 across row", 8'h5A);
    get_byte(0);
    i2c_stop();

    // R6: current-address read continues at C1
    i2c_start();
    put_byte(AR_ME, a);
    expect_rd("R6 current address read", 8'h6B);
    get_byte(0);
    i2c_stop();

    // R3: other pins / other prefix are ignored
    i2c_start();
    put_byte({4'b1010, 3'b100, 1'b0}, a); check(!a, "R3 wrong pins nack", a, 0);
    put_byte(8'h10, a); check(!a, "R3 pointer ignored", a, 0);
    put_byte(8'hFF, a); check(!a, "R3 data ignored", a, 0);
    i2c_stop();
    i2c_start();
    put_byte({4'b1011, 3'b101, 1'b1}, a); check(!a, "R3 wrong prefix nack", a, 0);
    i2c_stop();
    i2c_start();
    put_byte(AW_ME, a); check(a, "R3 no interval after ignored write", a, 1);
    put_byte(8'h10, a);
    i2c_start();
    put_byte(AR_ME, a);
    expect_rd("R3 store unchanged", 8'h11);
    get_byte(0);
    i2c_stop();

    wq(20);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule